// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder with Block Tail

This block turns a serial bit stream into a stream of two-bit code symbols for a forward error correcting channel. Each input bit that arrives with its valid strobe is combined with the two bits before it. Two exclusive-or taps over that three-bit window give the two code bits. The code is non-systematic: the data bit itself is never sent. The generator taps are octal 5 (current bit and the bit two back) and octal 6 (current bit and the previous bit).

The encoder keeps the two most recent data bits as its state, so it has four states. A synchronous flush clears that history at any time. To close a block cleanly, upstream raises a tail request. The encoder then feeds itself two zero bits over two cycles, emits the two resulting symbols and marks the second one with a block-done strobe. After that the state is back at zero, ready for the next block. Output is registered: each symbol appears one clock after the beat that produced it.

Top module: `conv_enc_r2k3`

## Requirements
- R1: After reset out_valid_o and block_done_o are 0, out_sym_o is 2'b00 and the bit history is all zero, so a first input bit of 1 gives symbol 2'b11.
- R2: out_sym_o[1] is the first code bit. It equals the current input bit XOR the input bit two accepted steps earlier (taps 101, octal 5).
- R3: out_sym_o[0] is the second code bit, sent after the first. It equals the current input bit XOR the previous accepted bit (taps 110, octal 6).
- R4: Starting from zero history, inputs 1,1,0,1 give symbols 2'b11, 2'b10, 2'b11, 2'b01 in that order.
- R5: A beat with in_valid_i high produces out_valid_o high with its symbol on the next clock. A cycle with no beat, no tail and no flush gives out_valid_o low on the next clock and leaves the history unchanged.
- R6: flush_i clears the history and any tail in progress on the next edge and takes priority over a data beat and a tail request in the same cycle. The next clock shows out_valid_o low.
- R7: When no tail is in progress, tail_req_i injects a zero bit in that cycle and another in the next cycle. Both produce symbols, and the history is all zero afterwards.
- R8: block_done_o is high together with the second tail symbol and is low on every other output cycle.
- R9: During the two tail cycles, in_valid_i and in_bit_i are ignored and a further tail_req_i does not restart the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of history and tail state |
| in_valid_i | input | 1 | Data beat strobe |
| in_bit_i | input | 1 | Data bit of the beat |
| tail_req_i | input | 1 | Start a two-zero block termination |
| out_valid_o | output | 1 | Code symbol valid |
| out_sym_o | output | 2 | Code symbol; bit 1 first code bit, bit 0 second |
| block_done_o | output | 1 | Marks the last tail symbol of a block |

## Verification
Two things can land in the same cycle. A tail request can arrive together with a data beat, and a beat can arrive on the second tail cycle. The bench drives data bits of 1 alongside the request and through the tail. It then checks that the two tail symbols match an injected pair of zeros, that the done strobe sits only on the second one, and that the next real bit encodes as if the history were zero. A flush that coincides with a beat is judged the same way: no output on the next clock, and a following 1 must encode as 2'b11.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  // one encoder advance: which bit enters and whether it closes a tail
  typedef struct packed {
    logic fire;
    logic data;
    logic last;
  } step_t;

  typedef struct packed {
    logic first;
    logic second;
  } sym_t;

endpackage

// File: rtl/conv_enc_tail_ctl.sv
module conv_enc_tail_ctl #(
  parameter int TAIL_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic tail_req_i,
  output logic tail_step_o,
  output logic tail_last_o,
  output logic busy_o
);
  localparam int CW = $clog2(TAIL_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          start;

  assign busy_o      = (cnt_q != '0);
  assign start       = tail_req_i & ~busy_o & ~flush_i;
  assign tail_step_o = (start | busy_o) & ~flush_i;

  always_comb begin
    if (busy_o) tail_last_o = (cnt_q == CW'(1)) & ~flush_i;
    else        tail_last_o = start & (TAIL_LEN == 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else if (start)   cnt_q <= CW'(TAIL_LEN - 1);
    else if (busy_o)  cnt_q <= cnt_q - CW'(1);
  end

endmodule

// File: rtl/conv_enc_hist.sv
module conv_enc_hist #(
  parameter int K = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         adv_i,
  input  logic         bit_i,
  output logic [K-2:0] hist_o,
  output logic [K-1:0] window_o
);
  // hist_o[K-2] is the newest stored bit
  logic [K-2:0] hist_q;

  assign hist_o   = hist_q;
  assign window_o = {bit_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (flush_i) hist_q <= '0;
    else if (adv_i)   hist_q <= window_o[K-1:1];
  end

endmodule

// File: rtl/conv_enc_gen.sv
module conv_enc_gen #(
  parameter int            K    = 3,
  parameter int            NG   = 2,
  parameter logic [NG*K-1:0] TAPS = 6'b101_110
) (
  input  logic [K-1:0]  window_i,
  output logic [NG-1:0] code_o
);
  // generator g sits at TAPS[(NG-g)*K-1 -: K] and drives code_o[NG-1-g]
  for (genvar g = 0; g < NG; g++) begin : g_tap
    localparam logic [K-1:0] T = TAPS[(NG-g)*K-1 -: K];
    assign code_o[NG-1-g] = ^(window_i & T);
  end

endmodule

// File: rtl/conv_enc_r2k3.sv
module conv_enc_r2k3
  import conv_enc_pkg::*;
#(
  parameter int            K     = 3,
  parameter logic [K-1:0]  GEN_A = 3'b101,
  parameter logic [K-1:0]  GEN_B = 3'b110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       in_valid_i,
  input  logic       in_bit_i,
  input  logic       tail_req_i,
  output logic       out_valid_o,
  output logic [1:0] out_sym_o,
  output logic       block_done_o
);
  localparam int TAIL_LEN = K - 1;
  localparam int NG       = 2;

  logic         tail_step, tail_last, tail_busy;
  logic [K-2:0] hist;
  logic [K-1:0] window;
  logic [NG-1:0] code;
  step_t        step;
  sym_t         sym_q;
  logic         valid_q, done_q;

  conv_enc_tail_ctl #(.TAIL_LEN(TAIL_LEN)) u_tail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .tail_req_i (tail_req_i),
    .tail_step_o(tail_step),
    .tail_last_o(tail_last),
    .busy_o     (tail_busy)
  );

  // tail zeros win over data; flush wins over both
  always_comb begin
    step = '0;
    if (!flush_i) begin
      if (tail_step) begin
        step.fire = 1'b1;
        step.data = 1'b0;
        step.last = tail_last;
      end else if (in_valid_i) begin
        step.fire = 1'b1;
        step.data = in_bit_i;
      end
    end
  end

  conv_enc_hist #(.K(K)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .adv_i   (step.fire),
    .bit_i   (step.data),
    .hist_o  (hist),
    .window_o(window)
  );

  conv_enc_gen #(.K(K), .NG(NG), .TAPS({GEN_A, GEN_B})) u_gen (
    .window_i(window),
    .code_o  (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      sym_q   <= '0;
    end else begin
      valid_q <= step.fire;
      done_q  <= step.fire & step.last;
      if (step.fire) begin
        sym_q.first  <= code[1];
        sym_q.second <= code[0];
      end
    end
  end

  assign out_valid_o  = valid_q;
  assign out_sym_o    = {sym_q.first, sym_q.second};
  assign block_done_o = done_q;

endmodule

// File: rtl/conv_enc_chk.sv
module conv_enc_chk #(
  parameter int K = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         flush_i,
  input logic         in_valid_i,
  input logic         tail_req_i,
  input logic         out_valid_o,
  input logic         block_done_o,
  input logic [K-2:0] hist_i,
  input logic         busy_i
);

  p_beat_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !flush_i && !busy_i) |=> out_valid_o);

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !tail_req_i && !flush_i && !busy_i) |=> (!out_valid_o && $stable(hist_i)));

  p_flush_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!out_valid_o && hist_i == '0 && !busy_i));

  p_done_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> (out_valid_o && hist_i == '0));

  p_done_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |=> !block_done_o);

  p_tail_runs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !flush_i) |=> out_valid_o);

endmodule

bind conv_enc_r2k3 conv_enc_chk #(.K(K)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .in_valid_i  (in_valid_i),
  .tail_req_i  (tail_req_i),
  .out_valid_o (out_valid_o),
  .block_done_o(block_done_o),
  .hist_i      (hist),
  .busy_i      (tail_busy)
);

// File: tb/conv_enc_r2k3_tb.sv
module conv_enc_r2k3_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, in_valid = 1'b0, in_bit = 1'b0, tail_req = 1'b0;
  logic       out_valid, block_done;
  logic [1:0] out_sym;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  // bench model of history: m1 previous bit, m2 bit two back
  logic m1 = 1'b0, m2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_enc_r2k3 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .in_valid_i(in_valid),
    .in_bit_i(in_bit), .tail_req_i(tail_req), .out_valid_o(out_valid),
    .out_sym_o(out_sym), .block_done_o(block_done)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (valid,sym,done)", req, act, exp);
    end
  endtask

  // drive one cycle, then look at registered outputs just after the edge
  task automatic cyc(logic v, logic b, logic t, logic f);
    in_valid = v; in_bit = b; tail_req = t; flush = f;
    @(posedge clk); #1;
    in_valid = 0; in_bit = 0; tail_req = 0; flush = 0;
  endtask

  function automatic logic [1:0] model(logic b);
    logic [1:0] s;
    s = {b ^ m2, b ^ m1};
    m2 = m1; m1 = b;
    return s;
  endfunction

  task automatic beat(string req, logic b);
    logic [1:0] e;
    e = model(b);
    cyc(1, b, 0, 0);
    chk(req, {out_valid, out_sym, block_done}, {1'b1, e, 1'b0});
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {out_valid, out_sym, block_done}, 4'b0000);
    beat("R1 first bit from zero history", 1'b1);
  endtask

  task automatic t_known_seq();
    cyc(0, 0, 0, 1); m1 = 0; m2 = 0;
    cyc(1, 1, 0, 0); chk("R4 sym0", {out_valid, out_sym, block_done}, 4'b1110);
    cyc(1, 1, 0, 0); chk("R4 sym1", {out_valid, out_sym, block_done}, 4'b1100);
    cyc(1, 0, 0, 0); chk("R4 sym2", {out_valid, out_sym, block_done}, 4'b1110);
    cyc(1, 1, 0, 0); chk("R4 sym3", {out_valid, out_sym, block_done}, 4'b1010);
    m1 = 1; m2 = 0;
  endtask

  task automatic t_tail_after_seq();
    // history 1,0 -> tail zeros give 01 then 10
    cyc(0, 0, 1, 0); chk("R7 tail sym0, R8 no done", {out_valid, out_sym, block_done}, 4'b1010);
    cyc(0, 0, 0, 0); chk("R7 tail sym1, R8 done", {out_valid, out_sym, block_done}, 4'b1101);
    cyc(0, 0, 0, 0); chk("R5 idle after tail", {out_valid, block_done}, 2'b00);
    m1 = 0; m2 = 0;
    beat("R7 history zero after tail", 1'b1);
  endtask

  task automatic t_gaps();
    cyc(0, 0, 0, 1); m1 = 0; m2 = 0;
    beat("R2 R3 gap seq a", 1'b1);
    cyc(0, 1, 0, 0); chk("R5 no beat no output", {out_valid, block_done}, 2'b00);
    beat("R5 history held over gap", 1'b1);
    beat("R2 R3 gap seq c", 1'b0);
    beat("R2 R3 gap seq d", 1'b0);
  endtask

  task automatic t_flush();
    beat("R6 pre a", 1'b1);
    beat("R6 pre b", 1'b1);
    cyc(1, 1, 1, 1); chk("R6 flush beats data and tail", {out_valid, block_done}, 2'b00);
    m1 = 0; m2 = 0;
    cyc(0, 0, 0, 0); chk("R6 no tail after flush", {out_valid, block_done}, 2'b00);
    beat("R6 history cleared", 1'b1);
  endtask

  task automatic t_tail_collide();
    cyc(0, 0, 0, 1); m1 = 0; m2 = 0;
    beat("R9 pre", 1'b1); // history 1,0
    cyc(1, 1, 1, 0); chk("R9 data ignored at tail start", {out_valid, out_sym, block_done}, 4'b1010);
    cyc(1, 1, 1, 0); chk("R9 second tail not restarted", {out_valid, out_sym, block_done}, 4'b1101);
    cyc(0, 0, 0, 0); chk("R9 tail over", {out_valid, block_done}, 2'b00);
    m1 = 0; m2 = 0;
    beat("R9 ignored bits left no trace", 1'b1);
  endtask

  task automatic t_tail_from_zero();
    cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 0); chk("R7 zero tail sym0", {out_valid, out_sym, block_done}, 4'b1000);
    cyc(0, 0, 0, 0); chk("R8 zero tail done", {out_valid, out_sym, block_done}, 4'b1001);
    m1 = 0; m2 = 0;
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:2] == 2'b00) begin
        cyc(0, lfsr[0], 0, 0);
        chk("R5 stream gap", {out_valid, block_done}, 2'b00);
      end else begin
        beat("R2 R3 stream", lfsr[0]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_known_seq();
    t_tail_after_seq();
    t_gaps();
    t_flush();
    t_tail_collide();
    t_tail_from_zero();
    t_stream();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule